// File: doc/BRIEF.md
# Packet Framer and CRC16 Checker for a Serial Link

This block sits between a block-write payload source and a byte-wide serial link. On the transmit side it takes a payload of a given total length and cuts it into packets of a programmable power-of-two size. Each packet starts with a one-byte start marker that shows whether the packet is the first, an inner or the final packet of the transfer. When protection is on, a two-byte CRC16 of that packet's payload follows the payload directly. The payload moves straight from the source to the link under valid/ready flow control, so no buffer is needed inside the block.

The receive side takes the byte stream of an incoming transfer of known length. It skips filler bytes until it finds a start marker, passes the payload bytes out, and checks the CRC16 at the end of each packet against its own running value. A mismatch stops the transfer at once and raises an error flag. The flag stays set until the next receive transfer starts. A transfer that finishes cleanly gives a one-cycle done pulse. The packet-size setting and the CRC enable are shared by both directions. Each direction samples them when its transfer starts.

Top module: `pkt_framer`

## Requirements
- R1: Each transmitted packet starts with a marker byte. Its upper nibble is 0xF and its low nibble is an order code: 1 for the first packet of a transfer that needs more than one packet, 2 for an inner packet, 3 for the final packet.
- R2: A transfer whose length is at most one packet size goes out as one packet with marker 0xF3.
- R3: The packet size is 256 << pkt_sel for pkt_sel 0 to 5, and 8192 for any larger pkt_sel value. Every packet except the last carries exactly one packet size of payload. The last packet carries the remaining bytes, in source order.
- R4: With crc_en set, two CRC bytes follow each packet's payload, high byte first. The CRC is CRC16 with polynomial 0x1021 (MSB first), preset to 0xFFFF at the start of every packet, and covers only that packet's payload bytes.
- R5: With crc_en clear, no CRC bytes are sent. The next marker, or the end of the transfer, follows the last payload byte directly.
- R6: A tx_start with tx_len of 4 or less is ignored. tx_busy stays low and no byte reaches the link.
- R7: pay_ready can be high only during payload transfer while link_ready is high. In that phase link_valid follows pay_valid and link_data follows pay_data. When idle, link_valid and pay_ready are low.
- R8: Before each packet, the receiver discards bytes whose upper nibble is not 0xF. It then presents that packet's payload bytes on rx_out_data with rx_out_valid, one per accepted input byte, in order.
- R9: With crc_en set, the receiver compares the received CRC (high byte first) with the CRC16 of R4 over the packet's payload. On a mismatch it sets rx_err, drops rx_busy and ignores the rest of the transfer. rx_err stays set until the next accepted rx_start clears it. A transfer with no mismatch ends with a one-cycle rx_done pulse and rx_err low.
- R10: With crc_en clear, the receiver expects no CRC bytes. The next marker search starts right after the last payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_sel | input | SEL_W | Packet size select, sampled at transfer start |
| crc_en | input | 1 | CRC16 append/check enable, sampled at transfer start |
| tx_start | input | 1 | Starts a transmit transfer |
| tx_len | input | LEN_W | Transmit payload length in bytes |
| pay_data | input | 8 | Payload byte from the source |
| pay_valid | input | 1 | Payload byte valid |
| pay_ready | output | 1 | Payload byte accepted |
| link_data | output | 8 | Byte to the link |
| link_valid | output | 1 | Link byte valid |
| link_ready | input | 1 | Link accepts the byte |
| tx_busy | output | 1 | Transmit transfer in progress |
| rx_start | input | 1 | Starts a receive transfer |
| rx_len | input | LEN_W | Expected receive payload length |
| rx_byte | input | 8 | Incoming link byte |
| rx_byte_valid | input | 1 | Incoming byte valid (always accepted) |
| rx_out_data | output | 8 | Received payload byte |
| rx_out_valid | output | 1 | Received payload byte valid |
| rx_busy | output | 1 | Receive transfer in progress |
| rx_err | output | 1 | Sticky CRC mismatch flag |
| rx_done | output | 1 | One-cycle pulse on clean end of a receive transfer |

## Verification
The properties assume that the payload source keeps pay_valid high with a stable byte until pay_ready accepts it, and that a new start is not issued while that direction is busy. The bench drives every transfer from one sequential task, so starts never overlap and the data is held until a handshake is seen. The receive side assumes that filler bytes before a marker never have 0xF as the upper nibble, so the bench pads with zero bytes only. It also assumes that the length given at rx_start matches the frames that are sent, and the bench builds each frame from that same length.

// File: rtl/pkt_fr_pkg.sv
package pkt_fr_pkg;

  localparam int          MIN_BLOCK  = 4;        // R6: lengths up to this are ignored
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [3:0]  TAG_MARK   = 4'hF;
  localparam logic [1:0]  ORD_FIRST  = 2'd1;
  localparam logic [1:0]  ORD_INNER  = 2'd2;
  localparam logic [1:0]  ORD_LAST   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAG,
    ST_PAY,
    ST_CRC_HI,
    ST_CRC_LO
  } fr_state_t;

  // One byte of CRC16, bit-serial, MSB of the data first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/pkt_size_dec.sv
module pkt_size_dec #(
  parameter int MIN_LOG = 8,
  parameter int MAX_LOG = 13,
  parameter int SEL_W   = 3,
  parameter int CNT_W   = MAX_LOG + 1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] size
);
  localparam int SPAN = MAX_LOG - MIN_LOG;

  // R3: out-of-range selections clamp to the largest size
  always_comb begin
    if (int'(sel) > SPAN) size = CNT_W'(1) << MAX_LOG;
    else                  size = CNT_W'(1) << (MIN_LOG + int'(sel));
  end
endmodule

// File: rtl/fr_tx.sv
module fr_tx
  import pkt_fr_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             crc_en,
  input  logic [CNT_W-1:0] psize,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic [7:0]       m_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic             busy,
  output logic             tag_phase
);
  fr_state_t        st;
  logic [LEN_W-1:0] rem;
  logic [CNT_W-1:0] cnt, psize_q, chunk;
  logic             first, crc_on, last_pkt, hs;
  logic [15:0]      crc;
  logic [1:0]       order;
  fr_state_t        after_pkt;

  always_comb begin
    last_pkt  = rem <= LEN_W'(psize_q);
    chunk     = last_pkt ? CNT_W'(rem) : psize_q;
    order     = last_pkt ? ORD_LAST : (first ? ORD_FIRST : ORD_INNER);  // R1, R2
    after_pkt = (rem == '0) ? ST_IDLE : ST_TAG;
    m_valid   = 1'b0;
    m_data    = 8'h00;
    s_ready   = 1'b0;
    case (st)
      ST_TAG:    begin m_valid = 1'b1; m_data = {TAG_MARK, 2'b00, order}; end
      ST_PAY:    begin m_valid = s_valid; m_data = s_data; s_ready = m_ready; end  // R7
      ST_CRC_HI: begin m_valid = 1'b1; m_data = crc[15:8]; end                    // R4
      ST_CRC_LO: begin m_valid = 1'b1; m_data = crc[7:0]; end
      default:   ;
    endcase
    hs        = m_valid & m_ready;
    busy      = st != ST_IDLE;
    tag_phase = st == ST_TAG;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rem     <= '0;
      cnt     <= '0;
      psize_q <= '0;
      first   <= 1'b0;
      crc_on  <= 1'b0;
      crc     <= CRC_PRESET;
    end else begin
      case (st)
        ST_IDLE: if (start && len > LEN_W'(MIN_BLOCK)) begin  // R6
          rem     <= len;
          first   <= 1'b1;
          crc_on  <= crc_en;
          psize_q <= psize;
          st      <= ST_TAG;
        end
        ST_TAG: if (m_ready) begin
          cnt   <= chunk;
          rem   <= rem - LEN_W'(chunk);
          first <= 1'b0;
          crc   <= CRC_PRESET;
          st    <= ST_PAY;
        end
        ST_PAY: if (hs) begin
          crc <= crc16_step(crc, s_data);
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) st <= crc_on ? ST_CRC_HI : after_pkt;  // R5
        end
        ST_CRC_HI: if (m_ready) st <= ST_CRC_LO;
        ST_CRC_LO: if (m_ready) st <= after_pkt;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fr_rx.sv
module fr_rx
  import pkt_fr_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             crc_en,
  input  logic [CNT_W-1:0] psize,
  input  logic [7:0]       r_data,
  input  logic             r_valid,
  output logic [7:0]       o_data,
  output logic             o_valid,
  output logic             busy,
  output logic             err,
  output logic             done,
  output logic             crc_bad
);
  fr_state_t        st;
  logic [LEN_W-1:0] rem;
  logic [CNT_W-1:0] cnt, psize_q, chunk;
  logic             crc_on, is_tag;
  logic [15:0]      crc;
  logic [7:0]       hi_q;

  always_comb begin
    chunk   = (rem <= LEN_W'(psize_q)) ? CNT_W'(rem) : psize_q;
    is_tag  = r_valid && (r_data[7:4] == TAG_MARK);                    // R8
    o_valid = (st == ST_PAY) && r_valid;
    o_data  = r_data;
    crc_bad = (st == ST_CRC_LO) && r_valid && ({hi_q, r_data} != crc);  // R9
    busy    = st != ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rem     <= '0;
      cnt     <= '0;
      psize_q <= '0;
      crc_on  <= 1'b0;
      crc     <= CRC_PRESET;
      hi_q    <= 8'h00;
      err     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start && len > LEN_W'(MIN_BLOCK)) begin
          rem     <= len;
          crc_on  <= crc_en;
          psize_q <= psize;
          err     <= 1'b0;
          st      <= ST_TAG;
        end
        ST_TAG: if (is_tag) begin
          cnt <= chunk;
          rem <= rem - LEN_W'(chunk);
          crc <= CRC_PRESET;
          st  <= ST_PAY;
        end
        ST_PAY: if (r_valid) begin
          crc <= crc16_step(crc, r_data);
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) begin
            if (crc_on)         st <= ST_CRC_HI;
            else if (rem == '0) begin st <= ST_IDLE; done <= 1'b1; end  // R10
            else                st <= ST_TAG;
          end
        end
        ST_CRC_HI: if (r_valid) begin
          hi_q <= r_data;
          st   <= ST_CRC_LO;
        end
        ST_CRC_LO: if (r_valid) begin
          if (crc_bad) begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end else if (rem == '0) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            st <= ST_TAG;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int MIN_LOG = 8,
  parameter int MAX_LOG = 13,
  parameter int SEL_W   = 3,
  parameter int LEN_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] pkt_sel,
  input  logic             crc_en,
  input  logic             tx_start,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [7:0]       pay_data,
  input  logic             pay_valid,
  output logic             pay_ready,
  output logic [7:0]       link_data,
  output logic             link_valid,
  input  logic             link_ready,
  output logic             tx_busy,
  input  logic             rx_start,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [7:0]       rx_byte,
  input  logic             rx_byte_valid,
  output logic [7:0]       rx_out_data,
  output logic             rx_out_valid,
  output logic             rx_busy,
  output logic             rx_err,
  output logic             rx_done
);
  localparam int CNT_W = MAX_LOG + 1;

  logic [CNT_W-1:0] pkt_bytes;
  logic             tx_tag_phase;
  logic             rx_crc_bad;

  pkt_size_dec #(.MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_size (
    .sel  (pkt_sel),
    .size (pkt_bytes)
  );

  fr_tx #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (tx_start),
    .len       (tx_len),
    .crc_en    (crc_en),
    .psize     (pkt_bytes),
    .s_data    (pay_data),
    .s_valid   (pay_valid),
    .s_ready   (pay_ready),
    .m_data    (link_data),
    .m_valid   (link_valid),
    .m_ready   (link_ready),
    .busy      (tx_busy),
    .tag_phase (tx_tag_phase)
  );

  fr_rx #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (rx_start),
    .len     (rx_len),
    .crc_en  (crc_en),
    .psize   (pkt_bytes),
    .r_data  (rx_byte),
    .r_valid (rx_byte_valid),
    .o_data  (rx_out_data),
    .o_valid (rx_out_valid),
    .busy    (rx_busy),
    .err     (rx_err),
    .done    (rx_done),
    .crc_bad (rx_crc_bad)
  );
endmodule

// File: rtl/fr_chk.sv
module fr_chk #(
  parameter int LEN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_start,
  input logic [LEN_W-1:0] tx_len,
  input logic             tx_busy,
  input logic             tag_phase,
  input logic [7:0]       link_data,
  input logic             link_valid,
  input logic             link_ready,
  input logic             pay_ready,
  input logic             rx_start,
  input logic             rx_busy,
  input logic             rx_err,
  input logic             rx_done,
  input logic             crc_bad
);
  assert_tag_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tag_phase && link_valid |-> link_data[7:4] == 4'hF && link_data[3:0] >= 4'd1 && link_data[3:0] <= 4'd3);

  assert_short_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy && tx_start && tx_len <= LEN_W'(4) |=> !tx_busy);

  assert_pay_needs_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> link_ready);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !link_valid && !pay_ready);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err && !rx_start |=> rx_err);

  assert_crc_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    crc_bad |=> rx_err && !rx_busy);

  assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !rx_err && !rx_busy);
endmodule

bind pkt_framer fr_chk #(.LEN_W(LEN_W)) u_fr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_start   (tx_start),
  .tx_len     (tx_len),
  .tx_busy    (tx_busy),
  .tag_phase  (tx_tag_phase),
  .link_data  (link_data),
  .link_valid (link_valid),
  .link_ready (link_ready),
  .pay_ready  (pay_ready),
  .rx_start   (rx_start),
  .rx_busy    (rx_busy),
  .rx_err     (rx_err),
  .rx_done    (rx_done),
  .crc_bad    (rx_crc_bad)
);

// File: tb/test_pkt_framer.sv
`timescale 1ns/1ps
module test_pkt_framer;
  localparam int LEN_W = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  pkt_sel = '0;
  logic        crc_en = 1'b0;
  logic        tx_start = 1'b0;
  logic [LEN_W-1:0] tx_len = '0;
  logic [7:0]  pay_data = '0;
  logic        pay_valid = 1'b0;
  logic        pay_ready;
  logic [7:0]  link_data;
  logic        link_valid;
  logic        link_ready = 1'b1;
  logic        tx_busy;
  logic        rx_start = 1'b0;
  logic [LEN_W-1:0] rx_len = '0;
  logic [7:0]  rx_byte = '0;
  logic        rx_byte_valid = 1'b0;
  logic [7:0]  rx_out_data;
  logic        rx_out_valid;
  logic        rx_busy, rx_err, rx_done;

  int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0;
  bit bp_mode = 1'b0;
  logic [7:0] tx_exp[$];
  string      tx_lbl[$];
  logic [7:0] rx_exp[$];
  string      rx_lbl[$];

  always #4 clk = ~clk;

  pkt_framer i_pkt_framer (.*);

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [15:0] tb_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x;
    x = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  function automatic logic [7:0] pay_byte(input int seed, input int i);
    return 8'((i * 13 + seed * 29 + (i >> 8)) & 255);
  endfunction

  function automatic int pkt_size(input int sel);
    return (sel > 5) ? 8192 : (256 << sel);
  endfunction

  // link-side stall pattern
  always @(posedge clk) begin
    #1;
    cyc++;
    link_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  // scoreboard monitors
  always @(negedge clk) if (rst_n) begin
    if (link_valid && link_ready) begin
      if (tx_exp.size() == 0) chk(1'b0, "R6 unexpected link byte", link_data, 0);
      else begin
        logic [7:0] e; string l;
        e = tx_exp.pop_front(); l = tx_lbl.pop_front();
        chk(link_data == e, l, link_data, e);
      end
    end
    if (tx_busy && !link_ready) chk(!pay_ready, "R7 stall", pay_ready, 0);
    if (rx_out_valid) begin
      if (rx_exp.size() == 0) chk(1'b0, "R9 byte after abort", rx_out_data, 0);
      else begin
        logic [7:0] e; string l;
        e = rx_exp.pop_front(); l = rx_lbl.pop_front();
        chk(rx_out_data == e, l, rx_out_data, e);
      end
    end
    if (rx_done) done_cnt++;
  end

  task automatic tx_run(input int len, input int sel, input bit crc_on, input int seed,
                        input bit bp, input string tag_req);
    int ps, rem, off, n, i;
    bit first, hs;
    logic [15:0] c;
    ps = pkt_size(sel);
    rem = (len > 4) ? len : 0;
    off = 0; first = 1'b1;
    while (rem > 0) begin
      logic [7:0] tg;
      if (rem <= ps) begin n = rem; tg = 8'hF3; end
      else begin n = ps; tg = first ? 8'hF1 : 8'hF2; end
      tx_exp.push_back(tg); tx_lbl.push_back(tag_req);
      c = 16'hFFFF;
      for (int k = 0; k < n; k++) begin
        tx_exp.push_back(pay_byte(seed, off + k)); tx_lbl.push_back("R3 payload");
        c = tb_crc(c, pay_byte(seed, off + k));
      end
      if (crc_on) begin
        tx_exp.push_back(c[15:8]); tx_lbl.push_back("R4 crc high");
        tx_exp.push_back(c[7:0]);  tx_lbl.push_back("R4 crc low");
      end
      rem -= n; off += n; first = 1'b0;
    end
    bp_mode = bp;
    @(posedge clk); #2;
    tx_start = 1'b1; tx_len = LEN_W'(len); pkt_sel = 3'(sel); crc_en = crc_on;
    @(posedge clk); #2;
    tx_start = 1'b0;
    if (len > 4) begin
      i = 0;
      while (i < len) begin
        pay_data = pay_byte(seed, i); pay_valid = 1'b1;
        @(negedge clk); hs = pay_ready;
        @(posedge clk); #2;
        if (hs) i++;
      end
      pay_valid = 1'b0;
      while (tx_busy) begin @(posedge clk); #2; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!tx_busy, "R6 idle after run", tx_busy, 0);
    chk(tx_exp.size() == 0, (crc_on ? "R3 stream complete" : "R5 stream complete"), tx_exp.size(), 0);
    bp_mode = 1'b0;
  endtask

  task automatic rx_run(input int len, input int sel, input bit crc_on, input int seed,
                        input int bad_pkt, input int gaps, input string req);
    logic [7:0] strm[$];
    int ps, rem, off, n, p, d0, sent;
    logic [15:0] c;
    ps = pkt_size(sel);
    rem = len; off = 0; p = 0;
    while (rem > 0) begin
      n = (rem <= ps) ? rem : ps;
      for (int g = 0; g < gaps; g++) strm.push_back(8'h00);
      strm.push_back(rem <= ps ? 8'hF3 : (p == 0 ? 8'hF1 : 8'hF2));
      c = 16'hFFFF;
      for (int k = 0; k < n; k++) begin
        strm.push_back(pay_byte(seed, off + k));
        c = tb_crc(c, pay_byte(seed, off + k));
        if (bad_pkt < 0 || p <= bad_pkt) begin
          rx_exp.push_back(pay_byte(seed, off + k)); rx_lbl.push_back(req);
        end
      end
      if (crc_on) begin
        strm.push_back(c[15:8]);
        strm.push_back(c[7:0] ^ ((p == bad_pkt) ? 8'h01 : 8'h00));
      end
      rem -= n; off += n; p++;
    end
    d0 = done_cnt;
    @(posedge clk); #2;
    rx_start = 1'b1; rx_len = LEN_W'(len); pkt_sel = 3'(sel); crc_en = crc_on;
    @(posedge clk); #2;
    rx_start = 1'b0;
    @(negedge clk);
    chk(!rx_err, "R9 err cleared by start", rx_err, 0);
    chk(rx_busy, "R8 busy after start", rx_busy, 1);
    @(posedge clk); #2;
    sent = 0;
    while (strm.size() > 0) begin
      rx_byte = strm.pop_front(); rx_byte_valid = 1'b1;
      @(posedge clk); #2;
      sent++;
      if (sent % 6 == 0) begin
        rx_byte_valid = 1'b0;
        @(posedge clk); #2;
      end
    end
    rx_byte_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rx_exp.size() == 0, req, rx_exp.size(), 0);
    chk(!rx_busy, "R9 idle at end", rx_busy, 0);
    if (bad_pkt >= 0) begin
      chk(rx_err, "R9 mismatch flagged", rx_err, 1);
      chk(done_cnt == d0, "R9 no done on error", done_cnt - d0, 0);
    end else begin
      chk(!rx_err, "R9 no false error", rx_err, 0);
      chk(done_cnt == d0 + 1, "R9 done pulse", done_cnt - d0, 1);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_busy && !link_valid && !pay_ready, "R7 reset idle", {tx_busy, link_valid, pay_ready}, 0);
    chk(!rx_busy && !rx_err && !rx_out_valid, "R9 reset idle", {rx_busy, rx_err, rx_out_valid}, 0);

    tx_run(600, 0, 1'b1, 1, 1'b0, "R1 tag");           // 256+256+88
    tx_run(256, 0, 1'b1, 2, 1'b0, "R2 single tag");    // exactly one packet
    tx_run(257, 0, 1'b1, 3, 1'b0, "R1 tag");           // last packet of one byte
    tx_run(5, 0, 1'b0, 4, 1'b0, "R2 single tag");      // minimum length, R5 no crc
    tx_run(1100, 1, 1'b1, 5, 1'b1, "R1 tag");          // 512-byte packets, link stalls (R7)
    tx_run(300, 7, 1'b1, 6, 1'b0, "R3 clamped size");  // sel 7 -> 8192, one packet
    tx_run(700, 0, 1'b0, 7, 1'b0, "R1 tag");           // R5 multi packet without crc
    tx_run(4, 0, 1'b1, 8, 1'b0, "R6");                 // R6 ignored

    rx_run(600, 0, 1'b1, 11, -1, 0, "R8 payload");
    rx_run(300, 0, 1'b1, 12, -1, 2, "R8 payload after filler");
    rx_run(700, 0, 1'b0, 13, -1, 1, "R10 payload without crc");
    rx_run(600, 0, 1'b1, 14, 1, 0, "R9 payload before abort");
    rx_run(5, 0, 1'b1, 15, -1, 0, "R9 payload after recovery");

    summary();
    $finish;
  end
endmodule